// File: doc/BRIEF.md
# Auto-Increment Buffer RAM Access Port

This block gives a host an indirect path into a 2048-byte buffer RAM through three byte-wide registers: a low pointer byte, a high pointer byte that also carries the transfer direction and the auto-step enable, and a data window. The host sets the direction and the start address, then moves a run of bytes through the data window. The pointer steps by one after each accepted data access when auto-step is on. It wraps at the top of the RAM, so a run can cross from the last page into page zero.

In read direction the port always holds the byte at the pointer in a one-entry prefetch buffer. Loading the pointer for reads starts a fetch at once. Each stepping read hands out the buffered byte and fetches the next one. While a fetch is in flight the port raises a busy flag. A data access made while busy is dropped, so the host polls busy between data accesses. The RAM side is a plain synchronous port: read data arrives one clock after the read strobe, and a write is taken in the cycle its strobe is high.

Top module: `ram_access_port`

## Requirements
- R1: After reset the pointer is 000h, the direction is write, auto-step is off, busy_o is 0 and rdata_o is 00h.
- R2: sel_i selects the register: 0 = data window, 1 = pointer low byte (address bits 7:0), 2 = pointer high byte (bit 7 = read direction when 1, bit 6 = auto-step enable, bits 2:0 = address bits 10:8; bits 5:3 are not stored and read as 0). A read result appears on rdata_o the cycle after the request and holds until the next read request.
- R3: In write direction, a data write when not busy drives ram_we_o, ram_addr_o = pointer and ram_wdata_o = wdata_i in the same cycle as the request.
- R4: With auto-step on, every accepted data access adds one to the pointer. With auto-step off the pointer does not change.
- R5: The pointer wraps from 7FFh to 000h.
- R6: A pointer high write with bit 7 set, or a pointer low write while in read direction, asserts ram_re_o with the new pointer in the next cycle and holds busy_o high for two cycles. The first data read afterwards returns the byte at that address.
- R7: An accepted data read with auto-step on starts a fetch at the stepped address, so successive reads return consecutive bytes. With auto-step off, a repeated read returns the same byte and issues no RAM read.
- R8: A data access while busy_o is high is dropped: a read returns 00h, a write produces no RAM write, and the pointer does not step.
- R9: A data access against the direction is dropped: a write in read direction produces no RAM write, a read in write direction returns 00h, and neither steps the pointer.
- R10: A pointer reload while a fetch is pending wins: the buffer ends up holding the byte at the newest address, and busy_o stays high until that byte is held.
- R11: A pointer register read in the cycle right after a data access returns the already stepped pointer.
- R12: Select code 3 reads as 00h, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 = write access, 0 = read access |
| sel_i | input | 2 | Register select |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, registered |
| busy_o | output | 1 | Prefetch in flight; data accesses are dropped |
| ram_addr_o | output | 11 | RAM address (current pointer) |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after ram_re_o |

## Verification
Two functions can fall in the same cycle here. One is a pointer reload that lands while an earlier fetch is still in flight; the reload can arrive in the cycle the stale byte is being captured. The other is a data access that arrives while a fetch is pending. The bench provokes the first with pointer writes on back-to-back cycles right after a read-direction load, and judges it by the byte that the first read returns and by how long busy_o stays high. It provokes the second with a data read in the cycle after a stepping read, and with a data write after a switch to write direction while a fetch is pending. A behavioural model updated on every clock judges these cases, together with read-backs of the pointer and a check of the RAM strobes.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_RSVD   = 2'd3
  } rap_sel_e;

  localparam int unsigned HI_RD_BIT  = 7;
  localparam int unsigned HI_INC_BIT = 6;
endpackage

// File: rtl/rap_pointer.sv
module rap_pointer #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_addr_i,
  input  logic              hi_rd_i,
  input  logic              hi_inc_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              rd_mode_o,
  output logic              auto_inc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o      <= '0;
      rd_mode_o  <= 1'b0;
      auto_inc_o <= 1'b0;
    end else if (ld_hi_i) begin
      rd_mode_o                  <= hi_rd_i;
      auto_inc_o                 <= hi_inc_i;
      ptr_o[ADDR_W-1:DATA_W]     <= hi_addr_i;
    end else if (ld_lo_i) begin
      ptr_o[DATA_W-1:0]          <= lo_i;
    end else if (step_i) begin
      ptr_o                      <= ptr_o + 1'b1;  // natural wrap at top of RAM
    end
  end

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ptr_o == ADDR_W'($past(ptr_o) + 1'b1));

  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (&ptr_o)) |=> ptr_o == '0);
endmodule

// File: rtl/rap_prefetch.sv
module rap_prefetch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_re_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] buf_o
);
  logic pend_q, wait_q;

  // pend_q: strobe the RAM; wait_q: RAM data valid this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      buf_o  <= '0;
    end else begin
      pend_q <= start_i;
      wait_q <= pend_q;
      if (wait_q) buf_o <= ram_rdata_i;
    end
  end

  assign ram_re_o = pend_q;
  assign busy_o   = pend_q | wait_q;

  p_busy_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  p_reload_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 busy_o);
endmodule

// File: rtl/ram_access_port.sv
module ram_access_port #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  import rap_pkg::*;

  localparam int unsigned HI_W  = ADDR_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - 2 - HI_W;

  rap_sel_e            sel;
  logic [ADDR_W-1:0]   ptr;
  logic                rd_mode, auto_inc;
  logic [DATA_W-1:0]   pf_buf;
  logic                ld_lo, ld_hi, data_rd_ok, data_wr_ok, step, start;
  logic [DATA_W-1:0]   rd_mux;

  assign sel        = rap_sel_e'(sel_i);
  assign ld_lo      = req_i && we_i && (sel == SEL_PTR_LO);
  assign ld_hi      = req_i && we_i && (sel == SEL_PTR_HI);
  assign data_rd_ok = req_i && !we_i && (sel == SEL_DATA) && rd_mode && !busy_o;
  assign data_wr_ok = req_i && we_i && (sel == SEL_DATA) && !rd_mode && !busy_o;
  assign step       = (data_rd_ok || data_wr_ok) && auto_inc;
  assign start      = (ld_lo && rd_mode) || (ld_hi && wdata_i[HI_RD_BIT])
                    || (data_rd_ok && auto_inc);

  rap_pointer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_lo_i    (ld_lo),
    .ld_hi_i    (ld_hi),
    .lo_i       (wdata_i),
    .hi_addr_i  (wdata_i[HI_W-1:0]),
    .hi_rd_i    (wdata_i[HI_RD_BIT]),
    .hi_inc_i   (wdata_i[HI_INC_BIT]),
    .step_i     (step),
    .ptr_o      (ptr),
    .rd_mode_o  (rd_mode),
    .auto_inc_o (auto_inc)
  );

  rap_prefetch #(.DATA_W(DATA_W)) u_pf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .ram_rdata_i (ram_rdata_i),
    .ram_re_o    (ram_re_o),
    .busy_o      (busy_o),
    .buf_o       (pf_buf)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA:   rd_mux = data_rd_ok ? pf_buf : '0;
      SEL_PTR_LO: rd_mux = ptr[DATA_W-1:0];
      SEL_PTR_HI: rd_mux = {rd_mode, auto_inc, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_mux;
  end

  assign ram_addr_o  = ptr;
  assign ram_we_o    = data_wr_ok;
  assign ram_wdata_o = wdata_i;

  p_rw_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_re_o && ram_we_o));

  p_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sel_i == SEL_DATA && busy_o) |=> ram_addr_o == $past(ram_addr_o));

  p_wr_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !rd_mode);

  p_load_fetch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && sel_i == SEL_PTR_HI && wdata_i[HI_RD_BIT]) |=> (ram_re_o && busy_o));

  p_seq_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_ok && auto_inc) |=> (ram_re_o && ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));
endmodule

// File: tb/test_ram_access_port.sv
module test_ram_access_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rdata;
  logic       busy;
  logic [10:0] ram_addr;
  logic       ram_re, ram_we;
  logic [7:0] ram_wdata, ram_q;
  logic [7:0] mem [2048];

  int n_chk = 0, n_err = 0;
  bit run = 1'b0, done = 1'b0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  ram_access_port i_ram_access_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sel_i(sel),
    .wdata_i(wd), .rdata_o(rdata), .busy_o(busy), .ram_addr_o(ram_addr),
    .ram_re_o(ram_re), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_q)
  );

  function automatic logic [7:0] f(int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = f(i);
    ram_q = 8'h00;
  end

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_q <= mem[ram_addr];
  end

  // behavioural reference model
  int m_ptr, m_rd, m_ai, m_cnt, m_pf_addr, m_buf, m_rdata;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_rd = 0; m_ai = 0; m_cnt = 0; m_pf_addr = 0; m_buf = 0; m_rdata = 0;
    end else begin
      int bz, trig;
      bz = (m_cnt > 0); trig = 0;
      if (req && !we) begin
        case (sel)
          2'd0: if (m_rd && !bz) begin
                  m_rdata = m_buf;
                  if (m_ai) begin m_ptr = (m_ptr + 1) & 'h7FF; trig = 1; end
                end else m_rdata = 0;
          2'd1: m_rdata = m_ptr & 'hFF;
          2'd2: m_rdata = (m_rd << 7) | (m_ai << 6) | (m_ptr >> 8);
          default: m_rdata = 0;
        endcase
      end
      if (req && we) begin
        case (sel)
          2'd0: if (!m_rd && !bz && m_ai) m_ptr = (m_ptr + 1) & 'h7FF;
          2'd1: begin m_ptr = (m_ptr & 'h700) | wd; trig = m_rd; end
          2'd2: begin
                  m_rd = wd[7]; m_ai = wd[6];
                  m_ptr = (m_ptr & 'hFF) | ((wd & 7) << 8); trig = m_rd;
                end
          default: ;
        endcase
      end
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_buf = mem[m_pf_addr];
      end
      if (trig) begin m_cnt = 2; m_pf_addr = m_ptr; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    chk({cur_tag, " busy per-cycle"}, 32'(busy), 32'(m_cnt > 0));
    chk({cur_tag, " rdata per-cycle"}, 32'(rdata), 32'(m_rdata));
  end

  task automatic cyc(logic r, logic w, logic [1:0] s, logic [7:0] d);
    @(negedge clk); req = r; we = w; sel = s; wd = d;
  endtask
  task automatic idle(int n);
    repeat (n) cyc(1'b0, 1'b0, 2'd0, 8'h00);
  endtask
  task automatic wr(logic [1:0] s, logic [7:0] d);
    cyc(1'b1, 1'b1, s, d);
  endtask
  task automatic rd_chk(logic [1:0] s, logic [7:0] exp, string tag);
    cyc(1'b1, 1'b0, s, 8'h00);
    idle(1);
    chk(tag, 32'(rdata), 32'(exp));
  endtask
  task automatic wr_data_chk(logic [7:0] d, logic [10:0] a, string tag);
    wr(2'd0, d);
    #1;
    chk({tag, " we"}, 32'(ram_we), 32'd1);
    chk({tag, " addr"}, 32'(ram_addr), 32'(a));
    chk({tag, " wdata"}, 32'(ram_wdata), 32'(d));
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    // R1 reset state
    cur_tag = "R1";
    chk("R1 rdata", 32'(rdata), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    rd_chk(2'd1, 8'h00, "R1 ptr lo");
    rd_chk(2'd2, 8'h00, "R1 ptr hi");

    // R2 register layout
    cur_tag = "R2";
    wr(2'd2, 8'h45); rd_chk(2'd2, 8'h45, "R2 hi readback");
    wr(2'd2, 8'h3F); rd_chk(2'd2, 8'h07, "R2 hi unstored bits");
    wr(2'd1, 8'hA5); rd_chk(2'd1, 8'hA5, "R2 lo readback");

    // R12 reserved select
    cur_tag = "R12";
    wr(2'd3, 8'hFF);
    rd_chk(2'd1, 8'hA5, "R12 lo unchanged");
    rd_chk(2'd2, 8'h07, "R12 hi unchanged");
    rd_chk(2'd3, 8'h00, "R12 reads zero");

    // R3 writes, R11 immediate pointer read
    cur_tag = "R3";
    wr(2'd2, 8'h41); wr(2'd1, 8'h23);
    wr_data_chk(8'h11, 11'h123, "R3 w0");
    wr_data_chk(8'h22, 11'h124, "R3 w1");
    wr_data_chk(8'h33, 11'h125, "R3 w2");
    cur_tag = "R11";
    rd_chk(2'd1, 8'h26, "R11 lo after write");
    rd_chk(2'd2, 8'h41, "R4 hi after steps");

    // R4 no auto-step
    cur_tag = "R4";
    wr(2'd2, 8'h01); wr(2'd1, 8'h30);
    wr_data_chk(8'h5A, 11'h130, "R4 no-step w0");
    wr_data_chk(8'h5A, 11'h130, "R4 no-step w1");
    rd_chk(2'd1, 8'h30, "R4 lo unchanged");

    // R5 wrap
    cur_tag = "R5";
    wr(2'd2, 8'h47); wr(2'd1, 8'hFF);
    wr_data_chk(8'hE1, 11'h7FF, "R5 top");
    wr_data_chk(8'hE2, 11'h000, "R5 wrapped");
    rd_chk(2'd1, 8'h01, "R5 lo");
    rd_chk(2'd2, 8'h40, "R5 hi");

    // R6 load triggers prefetch, R10 reload while pending
    cur_tag = "R6";
    wr(2'd2, 8'hC1);
    wr(2'd1, 8'h23);
    idle(1);
    chk("R6 busy", 32'(busy), 32'd1);
    chk("R6 re", 32'(ram_re), 32'd1);
    chk("R10 fetch addr", 32'(ram_addr), 32'h123);
    idle(3);
    rd_chk(2'd0, 8'h11, "R6 first read");

    // R7 sequential reads
    cur_tag = "R7";
    idle(3); rd_chk(2'd0, 8'h22, "R7 seq1");
    idle(3); rd_chk(2'd0, 8'h33, "R7 seq2");
    idle(3);

    // R8 read while busy
    cur_tag = "R8";
    cyc(1'b1, 1'b0, 2'd0, 8'h00);
    cyc(1'b1, 1'b0, 2'd0, 8'h00);
    idle(1);
    chk("R8 blocked read", 32'(rdata), 32'h0);
    idle(3);
    rd_chk(2'd1, 8'h27, "R8 no step");

    // R7 no auto-step repeat
    cur_tag = "R7";
    wr(2'd2, 8'h81); idle(3);
    rd_chk(2'd0, f('h127), "R7 hold0");
    chk("R7 no fetch", 32'(ram_re), 32'd0);
    rd_chk(2'd0, f('h127), "R7 hold1");
    rd_chk(2'd1, 8'h27, "R7 lo");

    // R9 wrong direction
    cur_tag = "R9";
    wr(2'd0, 8'h99); #1;
    chk("R9 no write in read dir", 32'(ram_we), 32'd0);
    rd_chk(2'd1, 8'h27, "R9 lo after write");
    wr(2'd1, 8'h27); idle(3);
    rd_chk(2'd0, f('h127), "R9 mem untouched");
    wr(2'd2, 8'h41); wr(2'd1, 8'h50);
    rd_chk(2'd0, 8'h00, "R9 read in write dir");
    rd_chk(2'd1, 8'h50, "R9 lo unstepped");

    // R8 write while busy
    cur_tag = "R8";
    wr(2'd2, 8'hC0);
    wr(2'd2, 8'h40);
    wr(2'd0, 8'h77); #1;
    chk("R8 blocked write", 32'(ram_we), 32'd0);
    idle(3);
    rd_chk(2'd1, 8'h50, "R8 lo unstepped");
    wr(2'd2, 8'hC0); idle(3);
    rd_chk(2'd0, f('h050), "R8 mem untouched");

    // R10 back-to-back reloads
    cur_tag = "R10";
    wr(2'd2, 8'hC2);
    wr(2'd1, 8'h10);
    wr(2'd1, 8'h11);
    idle(1);
    chk("R10 busy after reload", 32'(busy), 32'd1);
    idle(3);
    rd_chk(2'd0, f('h211), "R10 newest wins");
    idle(3);

    run = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule